// File: doc/BRIEF.md
# Local Interrupt Priority Core

This block sits beside one processor and decides which interrupt that processor takes next. Requests arrive as a vector number with a trigger kind. The block records them in a 256-entry pending set and moves one into a 256-entry in-service set each time the processor acknowledges. It tracks which vectors were level-triggered, so that completing one of them can tell the upstream interrupt routers to re-arm that line.

Priority works by class: the upper nibble of a vector is its class. A software-set task priority and the class of the highest vector still in service together give a processor priority. A pending request whose class is not above that priority is held back. If the processor acknowledges while the best request is held back, it receives a configurable spurious vector and no state changes. A control register carries the spurious vector, a global enable bit, and a bit that suppresses the end-of-interrupt broadcast.

Top module: `lipc_core`

## Requirements
- R1: While `rst` is high at a clock edge, the task priority becomes 0, the pending, in-service and level sets empty, and the control register becomes 0x00FF (block disabled, spurious vector 0xFF).
- R2: An accept strobe marks its vector pending. When `acc_level` is 1 the vector is also marked level-triggered. An edge-triggered vector later broadcasts nothing on completion.
- R3: The highest-numbered pending vector is always the one offered to the processor.
- R4: A pending vector is blocked when the processor priority is nonzero and the vector's upper nibble is less than or equal to the priority's upper nibble. With priority 0, class 0 vectors are not blocked.
- R5: An acknowledge while the best pending vector is blocked returns kind 2'b01 with the low byte of the control register, and it leaves pending and in-service state unchanged.
- R6: An acknowledge of a deliverable vector returns kind 2'b10 with that vector, moves it from pending to in-service, and reports `ack_valid` for exactly the cycle after `ack_req`.
- R7: An acknowledge with nothing pending returns kind 2'b00 and vector 0.
- R8: While control bit 8 is 0, `irq` stays low and every acknowledge returns kind 2'b00, with pending vectors kept.
- R9: An end-of-interrupt write clears the highest-numbered in-service vector. A lower vector it was blocking then becomes deliverable. With nothing in service, the write has no effect.
- R10: When the vector cleared by an end-of-interrupt is level-triggered and control bit 12 is 0, `eoi_bcast` pulses for one cycle, the cycle after the write, with `eoi_vec` equal to that vector.
- R11: When control bit 12 is 1, no end-of-interrupt broadcast occurs.
- R12: A task-priority write stores the 4-bit value in the upper nibble of an 8-bit register. `tpr_rdata` returns that 4-bit value.
- R13: Processor priority is the task priority when its upper nibble is at least the class of the highest in-service vector. Otherwise it is that class with a zero low nibble.
- R14: `irq` reflects the state left by any accept, acknowledge, end-of-interrupt, task-priority or control write, from the cycle after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Accept strobe for a new request |
| acc_vec | input | 8 | Vector of the request |
| acc_level | input | 1 | 1 = level-triggered request |
| ack_req | input | 1 | Processor acknowledge strobe |
| ack_valid | output | 1 | Acknowledge response valid (one cycle after `ack_req`) |
| ack_kind | output | 2 | 00 none, 01 spurious, 10 vector delivered |
| ack_vec | output | 8 | Returned vector |
| eoi_wr | input | 1 | End-of-interrupt write strobe |
| eoi_bcast | output | 1 | End-of-interrupt broadcast pulse |
| eoi_vec | output | 8 | Vector carried by the broadcast |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 4 | Task-priority value |
| tpr_rdata | output | 4 | Stored task-priority value |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control value: [7:0] spurious vector, [8] enable, [12] broadcast suppress |
| irq | output | 1 | Interrupt request to the processor |

## Verification
A corrupted pending or in-service bit shows at the ports on the next acknowledge. That acknowledge returns the wrong vector or the wrong kind, and `irq` has the wrong level in the cycle right after the disturbing write. A wrong processor priority shows up as a spurious return where a vector was due, or the reverse. A lost level bit shows as a missing `eoi_bcast` one cycle after the end-of-interrupt write. The scenarios therefore pair each acknowledge with an `irq` check and follow each end-of-interrupt with a further acknowledge, so that hidden state is brought out within one or two cycles.

// File: rtl/lipc_pkg.sv
package lipc_pkg;

    typedef enum logic [1:0] {
        ACK_NONE = 2'b00,
        ACK_SPUR = 2'b01,
        ACK_VEC  = 2'b10
    } ack_kind_e;

    localparam int CTL_W        = 16;
    localparam int CTL_EN_BIT   = 8;
    localparam int CTL_SUPP_BIT = 12;
    localparam logic [CTL_W-1:0] CTL_RST = 16'h00FF;

    typedef struct packed {
        logic      en;
        logic      supp;
        logic [7:0] spur;
    } ctl_view_t;

    function automatic ctl_view_t ctl_decode(input logic [CTL_W-1:0] raw);
        ctl_view_t c;
        c.en   = raw[CTL_EN_BIT];
        c.supp = raw[CTL_SUPP_BIT];
        c.spur = raw[7:0];
        return c;
    endfunction

endpackage

// File: rtl/lipc_prio_find.sv
module lipc_prio_find #(
    parameter int W     = 256,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < W; i++) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/lipc_prio_gate.sv
module lipc_prio_gate #(
    parameter int VEC_W = 8,
    parameter int CLS_W = VEC_W - 4
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_found,
    input  logic [VEC_W-1:0] isr_top,
    input  logic             irr_found,
    input  logic [VEC_W-1:0] irr_top,
    output logic [VEC_W-1:0] ppr,
    output logic             blocked
);
    localparam int LO_W = VEC_W - CLS_W;

    logic [CLS_W-1:0] tpr_cls, isr_cls, irr_cls, ppr_cls;

    always_comb begin
        tpr_cls = tpr[VEC_W-1 -: CLS_W];
        isr_cls = isr_found ? isr_top[VEC_W-1 -: CLS_W] : '0;
        irr_cls = irr_top[VEC_W-1 -: CLS_W];
        if (tpr_cls >= isr_cls) ppr = tpr;
        else                    ppr = {isr_cls, {LO_W{1'b0}}};
        ppr_cls = ppr[VEC_W-1 -: CLS_W];
        blocked = irr_found && (ppr != '0) && (irr_cls <= ppr_cls);
    end
endmodule

// File: rtl/lipc_vec_bank.sv
module lipc_vec_bank #(
    parameter int VEC_W   = 8,
    parameter int NUM_VEC = 1 << VEC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_en,
    input  logic [VEC_W-1:0]   acc_vec,
    input  logic               acc_level,
    input  logic               mov_en,
    input  logic [VEC_W-1:0]   mov_vec,
    input  logic               done_en,
    input  logic [VEC_W-1:0]   done_vec,
    output logic [NUM_VEC-1:0] irr,
    output logic [NUM_VEC-1:0] isr,
    output logic [NUM_VEC-1:0] tmr
);
    logic [NUM_VEC-1:0] irr_n, isr_n, tmr_n;

    always_comb begin
        irr_n = irr;
        isr_n = isr;
        tmr_n = tmr;
        if (done_en) isr_n[done_vec] = 1'b0;
        if (mov_en) begin
            irr_n[mov_vec] = 1'b0;
            isr_n[mov_vec] = 1'b1;
        end
        if (acc_en) begin
            irr_n[acc_vec] = 1'b1;
            if (acc_level) tmr_n[acc_vec] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr <= '0;
            isr <= '0;
            tmr <= '0;
        end else begin
            irr <= irr_n;
            isr <= isr_n;
            tmr <= tmr_n;
        end
    end

    // R2
    acc_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc_en)) |-> irr[$past(acc_vec)]);

    // R2
    acc_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(acc_en) && $past(acc_level)) |-> tmr[$past(acc_vec)]);

    // R6
    mov_isr_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mov_en)) |-> isr[$past(mov_vec)]);
endmodule

// File: rtl/lipc_core.sv
module lipc_core
    import lipc_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int CLS_W = VEC_W - 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [VEC_W-1:0] acc_vec,
    input  logic             acc_level,
    input  logic             ack_req,
    output logic             ack_valid,
    output logic [1:0]       ack_kind,
    output logic [VEC_W-1:0] ack_vec,
    input  logic             eoi_wr,
    output logic             eoi_bcast,
    output logic [VEC_W-1:0] eoi_vec,
    input  logic             tpr_wr,
    input  logic [CLS_W-1:0] tpr_wdata,
    output logic [CLS_W-1:0] tpr_rdata,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic             irq
);
    localparam int NUM_VEC = 1 << VEC_W;
    localparam int LO_W    = VEC_W - CLS_W;

    logic [NUM_VEC-1:0] irr, isr, tmr;
    logic               irr_found, isr_found, blocked;
    logic [VEC_W-1:0]   irr_top, isr_top, ppr;
    logic [VEC_W-1:0]   tpr_q;
    logic [CTL_W-1:0]   ctl_q;
    ctl_view_t          ctl;

    ack_kind_e          kind_n;
    logic [VEC_W-1:0]   vec_n;
    logic               mov_en, done_en, bcast_n;

    assign ctl = ctl_decode(ctl_q);

    lipc_vec_bank #(.VEC_W(VEC_W), .NUM_VEC(NUM_VEC)) u_bank (
        .clk(clk), .rst(rst),
        .acc_en(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
        .mov_en(mov_en), .mov_vec(irr_top),
        .done_en(done_en), .done_vec(isr_top),
        .irr(irr), .isr(isr), .tmr(tmr)
    );

    lipc_prio_find #(.W(NUM_VEC), .IDX_W(VEC_W)) u_irr_find (
        .req(irr), .found(irr_found), .idx(irr_top)
    );

    lipc_prio_find #(.W(NUM_VEC), .IDX_W(VEC_W)) u_isr_find (
        .req(isr), .found(isr_found), .idx(isr_top)
    );

    lipc_prio_gate #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_gate (
        .tpr(tpr_q), .isr_found(isr_found), .isr_top(isr_top),
        .irr_found(irr_found), .irr_top(irr_top),
        .ppr(ppr), .blocked(blocked)
    );

    // acknowledge decision
    always_comb begin
        kind_n = ACK_NONE;
        vec_n  = '0;
        mov_en = 1'b0;
        if (ack_req && ctl.en && irr_found) begin
            if (blocked) begin
                kind_n = ACK_SPUR;
                vec_n  = VEC_W'(ctl.spur);
            end else begin
                kind_n = ACK_VEC;
                vec_n  = irr_top;
                mov_en = 1'b1;
            end
        end
    end

    // end-of-interrupt decision
    always_comb begin
        done_en = eoi_wr && isr_found;
        bcast_n = done_en && tmr[isr_top] && !ctl.supp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tpr_q     <= '0;
            ctl_q     <= CTL_RST;
            ack_valid <= 1'b0;
            ack_kind  <= ACK_NONE;
            ack_vec   <= '0;
            eoi_bcast <= 1'b0;
            eoi_vec   <= '0;
        end else begin
            if (tpr_wr) tpr_q <= {tpr_wdata, {LO_W{1'b0}}};
            if (ctl_wr) ctl_q <= ctl_wdata;
            ack_valid <= ack_req;
            ack_kind  <= kind_n;
            ack_vec   <= vec_n;
            eoi_bcast <= bcast_n;
            eoi_vec   <= bcast_n ? isr_top : '0;
        end
    end

    assign tpr_rdata = tpr_q[VEC_W-1 -: CLS_W];
    assign irq       = ctl.en && irr_found && !blocked;

    // R6
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ack_req |=> ack_valid);

    // R5
    spur_vec_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ack_valid && ack_kind == ACK_SPUR) |-> ack_vec == $past(ctl_q[7:0]));

    // R8
    dis_none_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ack_req) && !$past(ctl_q[CTL_EN_BIT])) |-> ack_kind == ACK_NONE);

    // R10
    bcast_src_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && eoi_bcast) |-> $past(eoi_wr));

    // R11
    bcast_supp_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ctl_q[CTL_SUPP_BIT])) |-> !eoi_bcast);

    // R4
    gate_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && ppr != '0) |-> irr_top[VEC_W-1 -: CLS_W] > ppr[VEC_W-1 -: CLS_W]);
endmodule

// File: tb/sim_lipc_core.sv
module sim_lipc_core;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       acc_valid = 1'b0;
    logic [7:0] acc_vec = '0;
    logic       acc_level = 1'b0;
    logic       ack_req = 1'b0;
    logic       ack_valid;
    logic [1:0] ack_kind;
    logic [7:0] ack_vec;
    logic       eoi_wr = 1'b0;
    logic       eoi_bcast;
    logic [7:0] eoi_vec;
    logic       tpr_wr = 1'b0;
    logic [3:0] tpr_wdata = '0;
    logic [3:0] tpr_rdata;
    logic       ctl_wr = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic       irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lipc_core u0 (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_vec(acc_vec), .acc_level(acc_level),
        .ack_req(ack_req), .ack_valid(ack_valid), .ack_kind(ack_kind), .ack_vec(ack_vec),
        .eoi_wr(eoi_wr), .eoi_bcast(eoi_bcast), .eoi_vec(eoi_vec),
        .tpr_wr(tpr_wr), .tpr_wdata(tpr_wdata), .tpr_rdata(tpr_rdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic put_ctl(input logic [15:0] v);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic put_tpr(input logic [3:0] v);
        tpr_wr = 1'b1; tpr_wdata = v;
        @(negedge clk);
        tpr_wr = 1'b0;
    endtask

    task automatic accept(input logic [7:0] v, input logic lvl);
        acc_valid = 1'b1; acc_vec = v; acc_level = lvl;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic ack_expect(input string req, input logic [1:0] kind, input logic [7:0] v);
        ack_req = 1'b1;
        @(negedge clk);
        ack_req = 1'b0;
        chk(req, {15'd0, ack_valid}, 16'd1);
        chk(req, {14'd0, ack_kind}, {14'd0, kind});
        chk(req, {8'd0, ack_vec}, {8'd0, v});
    endtask

    task automatic eoi_expect(input string req, input logic bc, input logic [7:0] v);
        eoi_wr = 1'b1;
        @(negedge clk);
        eoi_wr = 1'b0;
        chk(req, {15'd0, eoi_bcast}, {15'd0, bc});
        if (bc) chk(req, {8'd0, eoi_vec}, {8'd0, v});
        @(negedge clk);
        chk(req, {15'd0, eoi_bcast}, 16'd0);
    endtask

    task automatic t_reset_and_enable();
        do_reset();
        chk("R1 irq", {15'd0, irq}, 16'd0);
        chk("R1 tpr", {12'd0, tpr_rdata}, 16'd0);
        ack_expect("R1 ack none after reset", 2'b00, 8'h00);
        accept(8'h50, 1'b0);
        chk("R8 irq disabled", {15'd0, irq}, 16'd0);
        ack_expect("R8 ack disabled", 2'b00, 8'h00);
        put_ctl(16'h01FF);
        chk("R14 irq after enable", {15'd0, irq}, 16'd1);
        ack_expect("R6 deliver 0x50", 2'b10, 8'h50);
        chk("R14 irq after ack", {15'd0, irq}, 16'd0);
        ack_expect("R7 nothing pending", 2'b00, 8'h00);
        eoi_expect("R2 edge no bcast", 1'b0, 8'h00);
    endtask

    task automatic t_order_and_spurious();
        do_reset();
        put_ctl(16'h01EF);
        accept(8'h31, 1'b0);
        accept(8'h92, 1'b0);
        accept(8'h60, 1'b0);
        chk("R3 irq", {15'd0, irq}, 16'd1);
        ack_expect("R3 highest first", 2'b10, 8'h92);
        chk("R13 in-service class blocks", {15'd0, irq}, 16'd0);
        ack_expect("R5 spurious", 2'b01, 8'hEF);
        eoi_expect("R9 eoi", 1'b0, 8'h00);
        chk("R9 irq resumes", {15'd0, irq}, 16'd1);
        ack_expect("R5 state kept, 0x60", 2'b10, 8'h60);
        eoi_expect("R9 eoi 2", 1'b0, 8'h00);
        ack_expect("R3 then 0x31", 2'b10, 8'h31);
        eoi_expect("R9 eoi 3", 1'b0, 8'h00);
        eoi_expect("R9 eoi empty", 1'b0, 8'h00);
        ack_expect("R9 empty all", 2'b00, 8'h00);
    endtask

    task automatic t_task_priority();
        do_reset();
        put_ctl(16'h01FF);
        put_tpr(4'h5);
        chk("R12 tpr read", {12'd0, tpr_rdata}, 16'h0005);
        accept(8'h55, 1'b0);
        chk("R4 equal class blocked", {15'd0, irq}, 16'd0);
        ack_expect("R4 spurious", 2'b01, 8'hFF);
        put_tpr(4'h4);
        chk("R12 tpr read 4", {12'd0, tpr_rdata}, 16'h0004);
        chk("R14 irq after tpr", {15'd0, irq}, 16'd1);
        ack_expect("R4 deliver 0x55", 2'b10, 8'h55);
        accept(8'h58, 1'b0);
        chk("R13 same class as in-service", {15'd0, irq}, 16'd0);
        accept(8'h61, 1'b0);
        chk("R13 higher class", {15'd0, irq}, 16'd1);
        do_reset();
        put_ctl(16'h01FF);
        accept(8'h05, 1'b0);
        chk("R4 class 0 with priority 0", {15'd0, irq}, 16'd1);
        ack_expect("R4 deliver 0x05", 2'b10, 8'h05);
    endtask

    task automatic t_broadcast();
        do_reset();
        put_ctl(16'h01FF);
        accept(8'h70, 1'b1);
        accept(8'h40, 1'b0);
        ack_expect("R6 deliver 0x70", 2'b10, 8'h70);
        ack_expect("R13 0x40 blocked", 2'b01, 8'hFF);
        eoi_expect("R10 level bcast", 1'b1, 8'h70);
        ack_expect("R6 deliver 0x40", 2'b10, 8'h40);
        eoi_expect("R2 edge no bcast", 1'b0, 8'h00);
        do_reset();
        put_ctl(16'h11FF);
        accept(8'h88, 1'b1);
        ack_expect("R6 deliver 0x88", 2'b10, 8'h88);
        eoi_expect("R11 suppressed", 1'b0, 8'h00);
        ack_expect("R9 in-service cleared", 2'b00, 8'h00);
    endtask

    initial begin
        #(4 * 50000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_and_enable();
        t_order_and_spurious();
        t_task_priority();
        t_broadcast();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule